// File: doc/BRIEF.md
# E1 Receive Alarm Detector

This block sits behind an already-aligned E1 receive framer and watches the incoming serial stream for six line and signaling alarm conditions. Each accepted bit arrives on `rx_bit` with a one-cycle qualifier `bit_en`, together with the framer's position markers. These are the bit index inside the 256-bit frame, the frame number inside the 16-frame multiframe, and a flag that tells align frames from non-align frames. Within a frame, bits 8k to 8k+7 form timeslot k, and bit index 8k+j carries bit j+1 of that slot, with bit 1 sent first.

Every alarm has its own rule for setting and a different rule for clearing, so it shows hysteresis. The windows used are timeslot 16 over a full multiframe, runs of consecutive multiframes or non-align frames, fixed 512-bit and 255-bit windows, and runs of consecutive zeros. Each level flag has a sticky copy. The copy is caught on the rising edge of its flag and released by a clear pulse, but only once the flag has dropped.

Flag vector positions, used by both `alm_lvl` and `alm_latch`: [0] signaling all ones, [1] signaling all zeros, [2] distant multiframe alarm, [3] unframed all ones, [4] remote alarm, [5] carrier loss.

Top module: `e1_rx_alarm_mon`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first window ends, every bit of `alm_lvl` and `alm_latch` is 0.
- R2: A multiframe window opens on the first bit of timeslot 16 in frame 0 and closes on the last bit of timeslot 16 in frame 15. When a window closes, flag [0] becomes 1 if the window held fewer than three zeros and 0 otherwise. A window cut short by reset is not evaluated.
- R3: At the same multiframe window close, flag [1] becomes 1 if all 128 timeslot-16 bits were zero and 0 if any was one.
- R4: Flag [2] samples bit 6 of timeslot 16 in frame 0 (bit index 133). It sets after that bit is one in two consecutive multiframes and clears after it is zero in two consecutive multiframes.
- R5: Accepted bits are grouped into back-to-back 512-bit windows counted from reset. At the end of each window, flag [3] becomes 1 if the window held at most two zeros and 0 otherwise.
- R6: Flag [4] samples bit 3 of timeslot 0 (bit index 2) in frames with `is_align` = 0. It sets after three consecutive such samples are one and clears after three consecutive samples are zero.
- R7: Flag [5] sets on the zero that completes a run of 255 consecutive zeros when `long_los` = 0, or a run of 2048 zeros when `long_los` = 1.
- R8: Accepted bits are also grouped into back-to-back 255-bit windows counted from reset. At the end of a window holding 32 or more ones, flag [5] clears, unless the set rule of R7 fires on that same bit.
- R9: Flags change only in the cycle after a `bit_en` cycle. Data and markers in cycles without `bit_en` have no effect.
- R10: A sticky bit in `alm_latch` becomes 1 one cycle after its flag rises, and it never sets without such a rise.
- R11: A `latch_clr` pulse clears every sticky bit whose flag is 0 in that cycle. It has no effect on a sticky bit whose flag is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_en | input | 1 | Qualifies `rx_bit` and the markers for one cycle |
| rx_bit | input | 1 | Received data bit |
| bit_idx | input | 8 | Bit index within the frame, 0 to 255 |
| frm_num | input | 4 | Frame number within the multiframe, 0 to 15 |
| is_align | input | 1 | 1 in align frames, 0 in non-align frames |
| long_los | input | 1 | Selects the 2048-zero carrier-loss threshold |
| latch_clr | input | 1 | Single-cycle clear for the sticky copies |
| alm_lvl | output | 6 | Level alarm flags |
| alm_latch | output | 6 | Sticky copies of the flags |

## Verification
The properties assume the markers describe a consistent framer position whenever `bit_en` is high, with frame numbers counting 0 to 15 and `is_align` set on even frames. They also assume `rst_n` stays high once released. The stimulus derives all markers from a single position counter that advances one step per accepted bit, starting in the middle of a multiframe so that an incomplete first window is present. Between bits, the stimulus inserts an idle cycle with random data, so the idle-cycle rules are exercised without ever breaking the marker sequence.

// File: rtl/e1_alarm_pkg.sv
package e1_alarm_pkg;
  localparam int ALM_N      = 6;
  localparam int SLOT_BITS  = 8;
  localparam int SBW        = $clog2(SLOT_BITS);

  localparam int A_SIG_ONES = 0;
  localparam int A_SIG_ZERO = 1;
  localparam int A_DIST_MF  = 2;
  localparam int A_UNFR_ONE = 3;
  localparam int A_REMOTE   = 4;
  localparam int A_CAR_LOSS = 5;

  typedef logic [ALM_N-1:0] alm_vec_t;
endpackage

// File: rtl/e1_win_count.sv
module e1_win_count #(
  parameter int   WIN   = 512,
  parameter int   SAT   = 3,
  parameter logic MATCH = 1'b0,
  localparam int  PW    = $clog2(WIN),
  localparam int  HW    = $clog2(SAT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          rx_bit,
  output logic          win_end,
  output logic [HW-1:0] hits_nxt
);
  logic [PW-1:0] pos_q, pos_d;
  logic [HW-1:0] hits_q, hits_d;

  always_comb begin
    win_end  = bit_en && (pos_q == PW'(WIN - 1));
    hits_nxt = hits_q;
    if ((rx_bit == MATCH) && (hits_q != HW'(SAT))) begin
      hits_nxt = hits_q + HW'(1);
    end
    pos_d  = pos_q;
    hits_d = hits_q;
    if (bit_en) begin
      if (win_end) begin
        pos_d  = '0;
        hits_d = '0;
      end else begin
        pos_d  = pos_q + PW'(1);
        hits_d = hits_nxt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      hits_q <= '0;
    end else begin
      pos_q  <= pos_d;
      hits_q <= hits_d;
    end
  end
endmodule

// File: rtl/e1_run_hyst.sv
module e1_run_hyst #(
  parameter int  N  = 2,
  localparam int RW = $clog2(N + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_en,
  input  logic smp_bit,
  output logic flag
);
  logic [RW-1:0] run_q, run_d, run_nx;
  logic          val_q, val_d;
  logic          flag_q, flag_d;

  always_comb begin
    if (smp_bit == val_q) begin
      run_nx = (run_q == RW'(N)) ? run_q : run_q + RW'(1);
    end else begin
      run_nx = RW'(1);
    end
    run_d  = run_q;
    val_d  = val_q;
    flag_d = flag_q;
    if (smp_en) begin
      run_d = run_nx;
      val_d = smp_bit;
      if (run_nx == RW'(N)) begin
        flag_d = smp_bit;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      val_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      val_q  <= val_d;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/e1_ts16_mon.sv
module e1_ts16_mon #(
  parameter int  MF_FRAMES = 16,
  parameter int  SIG_TS    = 16,
  parameter int  MIN_ZEROS = 3,
  parameter int  TSW       = 5,
  localparam int FW        = $clog2(MF_FRAMES),
  localparam int ZW        = $clog2(MIN_ZEROS + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bit_en,
  input  logic           rx_bit,
  input  logic [TSW-1:0] slot,
  input  logic [FW-1:0]  frm,
  input  logic [2:0]     bpos,
  output logic           sig_ones,
  output logic           sig_zeros
);
  logic          in_ts, mf_first, mf_last;
  logic          armed_q, armed_d, armed_nx;
  logic [ZW-1:0] zeros_q, zeros_d, zeros_base, zeros_nx;
  logic          one_q, one_d, one_nx;
  logic          ones_q, ones_d, zero_q, zero_d;

  always_comb begin
    in_ts    = bit_en && (slot == TSW'(SIG_TS));
    mf_first = in_ts && (frm == '0) && (bpos == 3'd0);
    mf_last  = in_ts && (frm == FW'(MF_FRAMES - 1)) && (bpos == 3'd7);
    armed_nx = armed_q | mf_first;

    zeros_base = mf_first ? '0 : zeros_q;
    zeros_nx   = zeros_base;
    if (!rx_bit && (zeros_base != ZW'(MIN_ZEROS))) begin
      zeros_nx = zeros_base + ZW'(1);
    end
    one_nx = (mf_first ? 1'b0 : one_q) | rx_bit;

    armed_d = armed_nx;
    zeros_d = zeros_q;
    one_d   = one_q;
    ones_d  = ones_q;
    zero_d  = zero_q;
    if (in_ts && armed_nx) begin
      zeros_d = zeros_nx;
      one_d   = one_nx;
      if (mf_last) begin
        ones_d = (zeros_nx < ZW'(MIN_ZEROS));
        zero_d = !one_nx;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      zeros_q <= '0;
      one_q   <= 1'b0;
      ones_q  <= 1'b0;
      zero_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      zeros_q <= zeros_d;
      one_q   <= one_d;
      ones_q  <= ones_d;
      zero_q  <= zero_d;
    end
  end

  assign sig_ones  = ones_q;
  assign sig_zeros = zero_q;
endmodule

// File: rtl/e1_los_det.sv
module e1_los_det #(
  parameter int  SHORT_RUN = 255,
  parameter int  LONG_RUN  = 2048,
  parameter int  CLR_WIN   = 255,
  parameter int  CLR_ONES  = 32,
  localparam int RW        = $clog2(LONG_RUN + 1),
  localparam int HW        = $clog2(CLR_ONES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic rx_bit,
  input  logic long_sel,
  output logic los
);
  logic [RW-1:0] run_q, run_d, run_nx, thr;
  logic          los_q, los_d;
  logic          win_end;
  logic [HW-1:0] ones_nxt;
  logic          set_hit, clr_hit;

  e1_win_count #(.WIN(CLR_WIN), .SAT(CLR_ONES), .MATCH(1'b1)) u_clr_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .rx_bit   (rx_bit),
    .win_end  (win_end),
    .hits_nxt (ones_nxt)
  );

  always_comb begin
    thr = long_sel ? RW'(LONG_RUN) : RW'(SHORT_RUN);
    if (rx_bit) begin
      run_nx = '0;
    end else if (run_q == RW'(LONG_RUN)) begin
      run_nx = run_q;
    end else begin
      run_nx = run_q + RW'(1);
    end
    set_hit = bit_en && !rx_bit && (run_nx >= thr);
    clr_hit = win_end && (ones_nxt >= HW'(CLR_ONES));
    run_d   = bit_en ? run_nx : run_q;
    los_d   = los_q;
    if (set_hit) begin
      los_d = 1'b1;
    end else if (clr_hit) begin
      los_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      los_q <= 1'b0;
    end else begin
      run_q <= run_d;
      los_q <= los_d;
    end
  end

  assign los = los_q;
endmodule

// File: rtl/e1_rx_alarm_mon.sv
module e1_rx_alarm_mon
  import e1_alarm_pkg::*;
#(
  parameter int  FRAME_BITS     = 256,
  parameter int  MF_FRAMES      = 16,
  parameter int  SIG_TS         = 16,
  parameter int  SIG_MIN_ZEROS  = 3,
  parameter int  DMA_BIT        = 6,
  parameter int  DMA_RUN        = 2,
  parameter int  RAI_BIT        = 3,
  parameter int  RAI_RUN        = 3,
  parameter int  UNFR_WIN       = 512,
  parameter int  UNFR_MAX_ZEROS = 2,
  parameter int  LOS_SHORT      = 255,
  parameter int  LOS_LONG       = 2048,
  parameter int  LOS_CLR_WIN    = 255,
  parameter int  LOS_CLR_ONES   = 32,
  localparam int BW             = $clog2(FRAME_BITS),
  localparam int FW             = $clog2(MF_FRAMES),
  localparam int TSW            = BW - SBW,
  localparam int UZW            = $clog2(UNFR_MAX_ZEROS + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             rx_bit,
  input  logic [BW-1:0]    bit_idx,
  input  logic [FW-1:0]    frm_num,
  input  logic             is_align,
  input  logic             long_los,
  input  logic             latch_clr,
  output logic [ALM_N-1:0] alm_lvl,
  output logic [ALM_N-1:0] alm_latch
);
  logic [1:0]     rs_q;
  logic           rst_i;
  logic [TSW-1:0] slot;
  logic [2:0]     bpos;
  logic           dma_smp, rai_smp;
  logic           unfr_end;
  logic [UZW-1:0] unfr_zeros;
  logic           unfr_q, unfr_d;
  alm_vec_t       lvl, lvl_d1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_i = rs_q[1];

  assign slot = bit_idx[BW-1:SBW];
  assign bpos = bit_idx[SBW-1:0];

  always_comb begin
    dma_smp = bit_en && (slot == TSW'(SIG_TS)) && (frm_num == '0) &&
              (bpos == 3'(DMA_BIT - 1));
    rai_smp = bit_en && (slot == '0) && !is_align &&
              (bpos == 3'(RAI_BIT - 1));
  end

  e1_ts16_mon #(
    .MF_FRAMES (MF_FRAMES),
    .SIG_TS    (SIG_TS),
    .MIN_ZEROS (SIG_MIN_ZEROS),
    .TSW       (TSW)
  ) u_ts16 (
    .clk       (clk),
    .rst_n     (rst_i),
    .bit_en    (bit_en),
    .rx_bit    (rx_bit),
    .slot      (slot),
    .frm       (frm_num),
    .bpos      (bpos),
    .sig_ones  (lvl[A_SIG_ONES]),
    .sig_zeros (lvl[A_SIG_ZERO])
  );

  e1_run_hyst #(.N(DMA_RUN)) u_dma (
    .clk     (clk),
    .rst_n   (rst_i),
    .smp_en  (dma_smp),
    .smp_bit (rx_bit),
    .flag    (lvl[A_DIST_MF])
  );

  e1_run_hyst #(.N(RAI_RUN)) u_rai (
    .clk     (clk),
    .rst_n   (rst_i),
    .smp_en  (rai_smp),
    .smp_bit (rx_bit),
    .flag    (lvl[A_REMOTE])
  );

  e1_win_count #(.WIN(UNFR_WIN), .SAT(UNFR_MAX_ZEROS + 1), .MATCH(1'b0)) u_unfr_win (
    .clk      (clk),
    .rst_n    (rst_i),
    .bit_en   (bit_en),
    .rx_bit   (rx_bit),
    .win_end  (unfr_end),
    .hits_nxt (unfr_zeros)
  );

  always_comb begin
    unfr_d = unfr_q;
    if (unfr_end) begin
      unfr_d = (unfr_zeros <= UZW'(UNFR_MAX_ZEROS));
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      unfr_q <= 1'b0;
    end else begin
      unfr_q <= unfr_d;
    end
  end
  assign lvl[A_UNFR_ONE] = unfr_q;

  e1_los_det #(
    .SHORT_RUN (LOS_SHORT),
    .LONG_RUN  (LOS_LONG),
    .CLR_WIN   (LOS_CLR_WIN),
    .CLR_ONES  (LOS_CLR_ONES)
  ) u_los (
    .clk      (clk),
    .rst_n    (rst_i),
    .bit_en   (bit_en),
    .rx_bit   (rx_bit),
    .long_sel (long_los),
    .los      (lvl[A_CAR_LOSS])
  );

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      lvl_d1 <= '0;
    end else begin
      lvl_d1 <= lvl;
    end
  end

  for (genvar g = 0; g < ALM_N; g++) begin : g_sticky
    logic lat_q, lat_d;

    always_comb begin
      lat_d = lat_q;
      if (latch_clr && !lvl[g]) begin
        lat_d = 1'b0;
      end
      if (lvl[g] && !lvl_d1[g]) begin
        lat_d = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_i) begin
      if (!rst_i) begin
        lat_q <= 1'b0;
      end else begin
        lat_q <= lat_d;
      end
    end

    assign alm_latch[g] = lat_q;
  end

  assign alm_lvl = lvl;
endmodule

// File: rtl/e1_rx_alarm_mon_chk.sv
module e1_rx_alarm_mon_chk #(
  parameter int BW     = 8,
  parameter int FW     = 4,
  parameter int SIG_TS = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_en,
  input logic          rx_bit,
  input logic [BW-1:0] bit_idx,
  input logic [FW-1:0] frm_num,
  input logic          is_align,
  input logic          latch_clr,
  input logic [5:0]    alm_lvl,
  input logic [5:0]    alm_latch
);
  logic dma_pt, rai_pt;
  assign dma_pt = bit_en && (bit_idx == BW'(SIG_TS * 8 + 5)) && (frm_num == '0);
  assign rai_pt = bit_en && (bit_idx == BW'(2)) && !is_align;

  assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(alm_lvl));

  assert_dma_point_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_pt |=> $stable(alm_lvl[2]));

  assert_rai_point_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rai_pt |=> $stable(alm_lvl[4]));

  assert_los_no_set_on_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && rx_bit) |=> !$rose(alm_lvl[5]));

  assert_sig_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    alm_lvl[1] |-> !alm_lvl[0]);

  for (genvar g = 0; g < 6; g++) begin : g_lat
    assert_latch_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alm_lvl[g]) |=> alm_latch[g]);

    assert_latch_no_spont_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!alm_lvl[g] && !alm_latch[g]) |=> !alm_latch[g]);

    assert_latch_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (alm_latch[g] && alm_lvl[g]) |=> alm_latch[g]);

    assert_latch_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (alm_latch[g] && !latch_clr) |=> alm_latch[g]);
  end
endmodule

bind e1_rx_alarm_mon e1_rx_alarm_mon_chk #(.BW(BW), .FW(FW), .SIG_TS(SIG_TS)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_en    (bit_en),
  .rx_bit    (rx_bit),
  .bit_idx   (bit_idx),
  .frm_num   (frm_num),
  .is_align  (is_align),
  .latch_clr (latch_clr),
  .alm_lvl   (alm_lvl),
  .alm_latch (alm_latch)
);

// File: tb/e1_rx_alarm_mon_tb.sv
module e1_rx_alarm_mon_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bit_en, rx_bit, is_align, long_los, latch_clr;
  logic [7:0] bit_idx;
  logic [3:0] frm_num;
  logic [5:0] alm_lvl, alm_latch;

  always #5 clk = ~clk;

  e1_rx_alarm_mon dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .rx_bit    (rx_bit),
    .bit_idx   (bit_idx),
    .frm_num   (frm_num),
    .is_align  (is_align),
    .long_los  (long_los),
    .latch_clr (latch_clr),
    .alm_lvl   (alm_lvl),
    .alm_latch (alm_latch)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_on = 1'b0;

  // reference model state
  logic [5:0] m_lvl = '0, m_lat = '0, m_prev = '0;
  bit   prev_en = 1'b0;
  bit   mf_on = 1'b0;
  int   mf_z = 0, mf_o = 0;
  int   d1 = 0, d0 = 0, r1 = 0, r0 = 0;
  int   u_cnt = 0, u_z = 0;
  int   l_run = 0, l_cnt = 0, l_one = 0;

  string lvl_req [6] = '{"R2", "R3", "R4", "R5", "R6", "R7 R8"};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lvl = '0; m_lat = '0; m_prev = '0; prev_en = 1'b0; mf_on = 1'b0;
      mf_z = 0; mf_o = 0; d1 = 0; d0 = 0; r1 = 0; r0 = 0;
      u_cnt = 0; u_z = 0; l_run = 0; l_cnt = 0; l_one = 0;
    end else begin
      logic [5:0] nl;
      int ts, bp, thr;
      for (int i = 0; i < 6; i++) begin
        nl[i] = (m_lvl[i] && !m_prev[i]) || (m_lat[i] && !(latch_clr && !m_lvl[i]));
      end
      m_prev  = m_lvl;
      m_lat   = nl;
      prev_en = bit_en;
      if (bit_en) begin
        ts = int'(bit_idx) / 8;
        bp = int'(bit_idx) % 8;
        if (ts == 16) begin
          if (frm_num == 0 && bp == 0) begin mf_on = 1'b1; mf_z = 0; mf_o = 0; end
          if (mf_on) begin
            if (rx_bit) mf_o++; else mf_z++;
            if (frm_num == 15 && bp == 7) begin
              m_lvl[0] = (mf_z < 3);
              m_lvl[1] = (mf_o == 0);
            end
          end
          if (frm_num == 0 && bp == 5) begin
            if (rx_bit) begin d1++; d0 = 0; end else begin d0++; d1 = 0; end
            if (d1 >= 2) m_lvl[2] = 1'b1;
            if (d0 >= 2) m_lvl[2] = 1'b0;
          end
        end
        if (ts == 0 && !is_align && bp == 2) begin
          if (rx_bit) begin r1++; r0 = 0; end else begin r0++; r1 = 0; end
          if (r1 >= 3) m_lvl[4] = 1'b1;
          if (r0 >= 3) m_lvl[4] = 1'b0;
        end
        if (!rx_bit) u_z++;
        if (u_cnt == 511) begin
          m_lvl[3] = (u_z < 3); u_cnt = 0; u_z = 0;
        end else u_cnt++;
        if (rx_bit) begin l_run = 0; l_one++; end else l_run++;
        thr = long_los ? 2048 : 255;
        if (!rx_bit && l_run >= thr) m_lvl[5] = 1'b1;
        else if (l_cnt == 254 && l_one >= 32) m_lvl[5] = 1'b0;
        if (l_cnt == 254) begin l_cnt = 0; l_one = 0; end else l_cnt++;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      for (int i = 0; i < 6; i++) begin
        n_chk++;
        if (alm_lvl[i] !== m_lvl[i]) begin
          n_fail++;
          $display("FAIL %s%s flag[%0d] actual %b expected %b at %0t", lvl_req[i],
                   prev_en ? "" : " R9", i, alm_lvl[i], m_lvl[i], $time);
        end
        n_chk++;
        if (alm_latch[i] !== m_lat[i]) begin
          n_fail++;
          $display("FAIL R10 R11 sticky[%0d] actual %b expected %b at %0t",
                   i, alm_latch[i], m_lat[i], $time);
        end
      end
    end
  end

  // stimulus
  int pos = 1000;
  int nbits = 0;
  logic [15:0] lf = 16'hACE1;

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_en    = 1'b1;
    rx_bit    = b;
    frm_num   = 4'(pos / 256);
    bit_idx   = 8'(pos % 256);
    is_align  = ((pos / 256) % 2) == 0;
    latch_clr = 1'b0;
    @(negedge clk);
    bit_en    = 1'b0;
    rx_bit    = 1'($urandom);
    bit_idx   = 8'($urandom);
    frm_num   = 4'($urandom);
    is_align  = 1'($urandom);
    nbits++;
    latch_clr = (nbits % 2500) == 0;
    pos = (pos + 1) % 4096;
  endtask

  task automatic send_run(input int kind, input int n);
    for (int k = 0; k < n; k++) begin
      logic b;
      case (kind)
        0: b = 1'b0;
        1: b = 1'b1;
        default: begin
          b  = lf[0];
          lf = {lf[0] ^ lf[2] ^ lf[3] ^ lf[5], lf[15:1]};
        end
      endcase
      send_bit(b);
    end
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0; bit_en = 1'b0; rx_bit = 1'b0; bit_idx = '0; frm_num = '0;
    is_align = 1'b0; long_los = 1'b0; latch_clr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_chk += 2;  // R1 reset state
    if (alm_lvl !== 6'b0) begin
      n_fail++; $display("FAIL R1 alm_lvl actual %b expected 000000", alm_lvl);
    end
    if (alm_latch !== 6'b0) begin
      n_fail++; $display("FAIL R1 alm_latch actual %b expected 000000", alm_latch);
    end
    rst_n = 1'b1;
    cmp_on = 1'b1;  // R1 continues through model compare until first window
    repeat (5) @(negedge clk);
    send_run(1, 3 * 4096);          // all ones: R2 R4 R5 R6 set
    send_run(2, 2 * 4096);          // random: clear
    send_run(0, 2 * 4096);          // all zeros: R3, R7 short threshold
    send_run(1, 1024);              // R8 clear
    long_los = 1'b1;
    send_run(0, 3000);              // R7 long threshold
    send_run(2, 600);
    send_run(1, 800);
    long_los = 1'b0;
    send_run(2, 4096);
    repeat (4) @(negedge clk);
    finish_up();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end
endmodule